// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings of a clock synthesizer: a feedback divider value, an output divider select and a two-bit test code. The settings come from one of two places. The first is a bank of parallel pins, which are transparent while the parallel latch control is low and are frozen on its rising edge. The second is a three-wire serial port made of data, clock and load lines. A 14-bit word is shifted in on the serial port and moved into the divider registers by the load line. If the load line is kept high, every serial clock edge updates the registers directly.

All control inputs are sampled by the block clock, and edges on them are found by comparing each input with its value one cycle earlier. The serial clock therefore has to stay well below the block clock. The block also drives a single observation output, `test_out`, which shows a signal chosen by the test code. The feedback divider output and the synthesizer output reach that selector as plain input ports. A range flag reports whether the feedback value lies in the band where the loop can lock. The master reset input is only passed on to the divider chain and never changes the stored settings. The block has no streaming data path, so every pin is a plain level.

Top module: `synth_cfg_port`

## Requirements
- R1: While `par_latch` is 0, `m_div` and `n_sel` take the values of `m_pin` and `n_pin` one clock later, on every cycle.
- R2: On a 0-to-1 edge of `par_latch`, the pin values are captured. While `par_latch` stays 1 and no serial load event occurs, `m_div` and `n_sel` ignore changes on the pins.
- R3: With `par_latch` at 1 and `ser_ld` at 0, each 0-to-1 edge of `ser_clk` shifts `ser_dat` into a 14-bit chain. Shifting alone leaves `m_div`, `n_sel` and `t_sel` unchanged.
- R4: The serial word is sent first bit first in this order: test code bit 1, test code bit 0, one unused slot, N bit 1, N bit 0, then M bit 8 down to M bit 0. The value in the unused slot has no effect.
- R5: A 0-to-1 edge of `ser_ld` (with `par_latch` at 1) copies the chain into `m_div`, `n_sel` and `t_sel`. Once `ser_ld` falls, the values hold while more bits are shifted.
- R6: While `ser_ld` is 1 and `par_latch` is 1, each `ser_clk` rising edge shifts the chain and loads the shifted word into the registers on that same update.
- R7: With `par_latch` at 1, `test_out` follows `t_sel`: code 0 gives 0, code 1 gives `ser_dat`, code 2 gives `fb_div_in`, and code 3 gives `synth_in`.
- R8: `test_out` is 0 whenever `par_latch` is 0, whatever the test code.
- R9: `mr` does not change `m_div`, `n_sel` or `t_sel`. `div_clr` equals `mr` delayed by one clock.
- R10: After `rst_n` is asserted, `t_sel` is 0. The pin values become the configuration with no serial activity needed.
- R11: `m_valid` is 1 exactly when `m_div` is between the parameters `M_LO` and `M_HI` inclusive (25 and 31 by default).
- R12: Serial clock and load activity while `par_latch` is 0 changes neither the registers nor the contents of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all control inputs |
| rst_n | input | 1 | Active-low reset of the configuration logic |
| mr | input | 1 | Master reset meant for the divider chain |
| par_latch | input | 1 | Parallel latch control: 0 makes the pins transparent, 1 holds them |
| m_pin | input | M_W | Parallel feedback divider value |
| n_pin | input | N_W | Parallel output divider select |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load line |
| fb_div_in | input | 1 | Feedback divider output to be observed |
| synth_in | input | 1 | Synthesizer output to be observed |
| m_div | output | M_W | Stored feedback divider value |
| n_sel | output | N_W | Stored output divider select |
| t_sel | output | 2 | Stored test code |
| m_valid | output | 1 | Feedback value is inside the lock range |
| test_out | output | 1 | Observation output chosen by the test code |
| div_clr | output | 1 | Registered copy of mr for the dividers |

## Verification
The bench sends whole words and compares each field against a model of the chain built from the bit order. A reversed or off-by-one field split would therefore put N bits into M or move the test code. A frame with the unused slot set to 1 must give the same result as one with it at 0; a design that counts the slot as data would shift the fields. The bench also checks that shifting with the load line low leaves the registers alone, and that holding the load line high makes each clock update the registers. A design that shifts while the parallel control is low is caught through the chain contents, which the bench reads by issuing a later load. The test selector is driven with all four codes, and its output is checked to be forced low in parallel mode.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  // Test code values; the order is part of the observable behaviour.
  typedef enum logic [1:0] {
    TSEL_LOW   = 2'd0,
    TSEL_SDAT  = 2'd1,
    TSEL_FBDIV = 2'd2,
    TSEL_SYNTH = 2'd3
  } tsel_e;

  localparam int T_W    = 2;
  localparam int GAP_W  = 1;

  function automatic int frame_width(input int m_w, input int n_w);
    return T_W + GAP_W + n_w + m_w;
  endfunction
endpackage

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
    assign rise[i] = d[i] & ~q[i];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [FW-1:0] q,
  output logic [FW-1:0] nxt
);
  assign nxt = {q[FW-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= nxt;
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_pins,
  input  logic [M_W-1:0]       m_pin,
  input  logic [N_W-1:0]       n_pin,
  input  logic                 load_word,
  input  logic [M_W-1:0]       m_w,
  input  logic [N_W-1:0]       n_w,
  input  logic [cfg_pkg::T_W-1:0] t_w,
  output logic [M_W-1:0]       m_q,
  output logic [N_W-1:0]       n_q,
  output logic [cfg_pkg::T_W-1:0] t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (load_pins) begin
      m_q <= m_pin;
      n_q <= n_pin;
    end else if (load_word) begin
      m_q <= m_w;
      n_q <= n_w;
      t_q <= t_w;
    end
  end
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux (
  input  logic                      en,
  input  logic [cfg_pkg::T_W-1:0]   code,
  input  logic                      sdat,
  input  logic                      fb,
  input  logic                      synth,
  output logic                      y
);
  import cfg_pkg::*;
  always_comb begin
    y = 1'b0;
    if (en) begin
      unique case (tsel_e'(code))
        TSEL_LOW:   y = 1'b0;
        TSEL_SDAT:  y = sdat;
        TSEL_FBDIV: y = fb;
        TSEL_SYNTH: y = synth;
        default:    y = 1'b0;
      endcase
    end
  end

  // p_par_low_r8: selector output is quiet while the parallel path is open
  always_comb begin
    if (!en) p_par_low_r8: assert (y == 1'b0);
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int M_W  = 9,
  parameter int N_W  = 2,
  parameter int M_LO = 25,
  parameter int M_HI = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_latch,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           fb_div_in,
  input  logic           synth_in,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_sel,
  output logic [1:0]     t_sel,
  output logic           m_valid,
  output logic           test_out,
  output logic           div_clr
);
  import cfg_pkg::*;
  localparam int FW    = frame_width(M_W, N_W);
  localparam int N_LSB = M_W;
  localparam int T_LSB = FW - T_W;

  logic [2:0] ctl_d, ctl_q, ctl_rise;
  assign ctl_d = {ser_ld, ser_clk, par_latch};

  cfg_edge #(.W(3)) i_edge (
    .clk(clk), .rst_n(rst_n), .d(ctl_d), .q(ctl_q), .rise(ctl_rise)
  );

  logic par_q, sclk_rise, ld_rise, ser_en;
  assign par_q     = ctl_q[0];
  assign sclk_rise = ctl_rise[1];
  assign ld_rise   = ctl_rise[2];
  assign ser_en    = par_latch & par_q;

  logic          shift_en, load_live, load_snap, load_pins;
  logic [FW-1:0] chain_q, chain_nxt, word;
  assign shift_en  = ser_en & sclk_rise;
  assign load_live = shift_en & ser_ld;
  assign load_snap = ser_en & ld_rise & ~sclk_rise;
  assign load_pins = ~ser_en;
  assign word      = load_live ? chain_nxt : chain_q;

  cfg_shift #(.FW(FW)) i_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(ser_dat),
    .q(chain_q), .nxt(chain_nxt)
  );

  cfg_regs #(.M_W(M_W), .N_W(N_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .load_pins(load_pins), .m_pin(m_pin), .n_pin(n_pin),
    .load_word(load_live | load_snap),
    .m_w(word[M_W-1:0]), .n_w(word[N_LSB +: N_W]), .t_w(word[T_LSB +: T_W]),
    .m_q(m_div), .n_q(n_sel), .t_q(t_sel)
  );

  cfg_test_mux i_tmux (
    .en(par_latch), .code(t_sel), .sdat(ser_dat), .fb(fb_div_in),
    .synth(synth_in), .y(test_out)
  );

  assign m_valid = (m_div >= M_W'(M_LO)) && (m_div <= M_W'(M_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_clr <= 1'b0;
    else        div_clr <= mr;
  end

  // p_pass_r1: open parallel path copies the pins one cycle later
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !par_latch |=> (m_div == $past(m_pin)) && (n_sel == $past(n_pin)));

  // p_hold_r2: held parallel state with no serial event keeps M and N
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (par_latch && par_q && !ld_rise && !(ser_ld && sclk_rise)) |=> $stable(m_div) && $stable(n_sel));

  // p_shift_quiet_r3: plain shifting leaves the test code alone
  p_shift_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && sclk_rise && !ser_ld) |=> $stable(t_sel));

  // p_snap_r5: load edge transfers the chain's test field
  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ld_rise && !sclk_rise) |=> t_sel == $past(chain_q[T_LSB +: T_W]));

  // p_live_r6: held load line makes the new bit the M lsb at once
  p_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ser_ld && sclk_rise) |=> m_div[0] == $past(ser_dat));

  // p_mr_r9: divider clear follows master reset by one clock
  p_mr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> div_clr);
endmodule

// File: tb/test_synth_cfg_port.sv
`timescale 1ns/1ps
module test_synth_cfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr = 1'b0, par_latch = 1'b0;
  logic [8:0] m_pin = '0;
  logic [1:0] n_pin = '0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic       fb_div_in = 1'b0, synth_in = 1'b0;
  logic [8:0] m_div;
  logic [1:0] n_sel, t_sel;
  logic       m_valid, test_out, div_clr;

  int checks = 0, fails = 0;
  logic [13:0] mdl = '0;  // expected chain contents

  always #4 clk = ~clk;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_latch(par_latch),
    .m_pin(m_pin), .n_pin(n_pin), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .fb_div_in(fb_div_in), .synth_in(synth_in),
    .m_div(m_div), .n_sel(n_sel), .t_sel(t_sel), .m_valid(m_valid),
    .test_out(test_out), .div_clr(div_clr)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    ser_clk = 1'b1;
    cyc(2);
    ser_clk = 1'b0;
    cyc(2);
    if (par_latch) mdl = {mdl[12:0], b};
  endtask

  task automatic send_frame(input logic [1:0] t, input logic gap,
                            input logic [1:0] n, input logic [8:0] m);
    logic [13:0] w;
    w = {t, gap, n, m};
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_ld;
    ser_ld = 1'b1; cyc(2);
    ser_ld = 1'b0; cyc(2);
  endtask

  task automatic load_cfg(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    send_frame(t, 1'b0, n, m);
    pulse_ld();
  endtask

  task automatic t_reset;
    m_pin = 9'd28; n_pin = 2'd1; par_latch = 1'b0;
    rst_n = 1'b0; cyc(3);
    check("R10 t_sel after reset", t_sel, 0);
    check("R8 test_out after reset", test_out, 0);
    rst_n = 1'b1; cyc(1);
    check("R10 pins become config M", m_div, 28);
    check("R10 pins become config N", n_sel, 1);
  endtask

  task automatic t_parallel;
    m_pin = 9'd24; n_pin = 2'd3; cyc(1);
    check("R1 pass M", m_div, 24);
    check("R1 pass N", n_sel, 3);
    check("R11 below range", m_valid, 0);
    m_pin = 9'd25; cyc(1); check("R11 low bound", m_valid, 1);
    m_pin = 9'd31; cyc(1); check("R11 high bound", m_valid, 1);
    m_pin = 9'd32; cyc(1); check("R11 above range", m_valid, 0);
    m_pin = 9'd27; n_pin = 2'd2; cyc(1);
    par_latch = 1'b1; cyc(1);
    m_pin = 9'd100; n_pin = 2'd0; cyc(3);
    check("R2 held M", m_div, 27);
    check("R2 held N", n_sel, 2);
  endtask

  task automatic t_serial;
    send_frame(2'd1, 1'b0, 2'd0, 9'd29);
    check("R3 shift keeps M", m_div, 27);
    check("R3 shift keeps T", t_sel, 0);
    pulse_ld();
    check("R4 R5 M field", m_div, 29);
    check("R4 R5 N field", n_sel, 0);
    check("R4 R5 T field", t_sel, 1);
    send_frame(2'd2, 1'b1, 2'd3, 9'd300);
    check("R5 held after fall", m_div, 29);
    pulse_ld();
    check("R4 gap ignored M", m_div, 300);
    check("R4 gap ignored N", n_sel, 3);
    check("R4 gap ignored T", t_sel, 2);
  endtask

  task automatic t_live;
    ser_ld = 1'b1; cyc(2);
    send_bit(1'b1);
    check("R6 live M", m_div, int'(mdl[8:0]));
    check("R6 live N", n_sel, int'(mdl[10:9]));
    send_bit(1'b0);
    check("R6 live M second", m_div, int'(mdl[8:0]));
    check("R6 live T", t_sel, int'(mdl[13:12]));
    ser_ld = 1'b0; cyc(2);
  endtask

  task automatic t_testmux;
    load_cfg(2'd0, 2'd1, 9'd26);
    synth_in = 1'b1; fb_div_in = 1'b1; ser_dat = 1'b1; #2;
    check("R7 code0 low", test_out, 0);
    load_cfg(2'd1, 2'd1, 9'd26);
    ser_dat = 1'b1; #2; check("R7 code1 data hi", test_out, 1);
    ser_dat = 1'b0; #2; check("R7 code1 data lo", test_out, 0);
    load_cfg(2'd2, 2'd1, 9'd26);
    fb_div_in = 1'b0; #2; check("R7 code2 lo", test_out, 0);
    fb_div_in = 1'b1; #2; check("R7 code2 hi", test_out, 1);
    load_cfg(2'd3, 2'd1, 9'd26);
    synth_in = 1'b0; #2; check("R7 code3 lo", test_out, 0);
    synth_in = 1'b1; #2; check("R7 code3 hi", test_out, 1);
    cyc(1);
  endtask

  task automatic t_par_mode;
    logic [13:0] saved;
    saved = mdl;
    par_latch = 1'b0; m_pin = 9'd30; n_pin = 2'd2; cyc(1);
    check("R8 low in parallel", test_out, 0);
    check("R10 T kept in parallel", t_sel, 3);
    send_frame(2'd1, 1'b0, 2'd1, 9'd5);
    pulse_ld();
    check("R12 serial ignored M", m_div, 30);
    check("R12 serial ignored N", n_sel, 2);
    par_latch = 1'b1; cyc(2);
    pulse_ld();
    check("R12 chain untouched M", m_div, int'(saved[8:0]));
    check("R12 chain untouched T", t_sel, int'(saved[13:12]));
  endtask

  task automatic t_mr;
    logic [8:0] m0; logic [1:0] n0, t0;
    m0 = m_div; n0 = n_sel; t0 = t_sel;
    mr = 1'b1; cyc(1);
    check("R9 div_clr follows", div_clr, 1);
    cyc(2);
    check("R9 M unchanged", m_div, int'(m0));
    check("R9 N unchanged", n_sel, int'(n0));
    check("R9 T unchanged", t_sel, int'(t0));
    mr = 1'b0; cyc(1);
    check("R9 div_clr release", div_clr, 0);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_parallel();
    t_serial();
    t_live();
    t_testmux();
    t_par_mode();
    t_mr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule